// File: doc/BRIEF.md
# Dual-Bank Direct Digital Synthesizer

This block is a numerically controlled oscillator core driven by a single master clock. Two frequency tuning words and two phase offset words are held in register banks. On every clock edge the tuning word chosen by `freq_sel` is added into a 28-bit phase accumulator. The top 12 bits of the accumulator are then offset by the phase word chosen by `phase_sel`. The offset phase drives one of three sample shapes on a 10-bit output: sine, triangle or square. It also drives a 1-bit clock output taken from the phase MSB, which can optionally be halved in frequency. The output frequency is `word * fclk / 2^28`. The usable range runs from zero up to half the master clock.

Bank writes and bank-select changes take effect on a clock edge and never clear the accumulator, so a frequency or phase hop is continuous in phase. The sample path has two register stages after the accumulator. The first holds the offset phase. The second is a small output state machine with two states. `ST_ACTIVE` shapes samples. `ST_ASLEEP` holds the sample at mid-scale. The machine moves from `ST_ACTIVE` to `ST_ASLEEP` when `sleep` is sampled high, and from `ST_ASLEEP` back to `ST_ACTIVE` when `sleep` is sampled low. Reset forces `ST_ACTIVE`. The clock output keeps running in both states.

Top module: `dds_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, all four bank words, the offset phase and the halving flop. It drives `sample_out` to 512 and `clk_out` to 0, and returns the output machine to `ST_ACTIVE`.
- R2: After each clock edge out of reset, the accumulator equals its previous value plus bank word `freq_sel` (0 or 1), modulo 2^28.
- R3: A bank write (`freq_we` or `phase_we` with a bank index in `*_wsel`) updates that word at the clock edge, and the new word is used from the next edge on. Neither a write nor a select change alters the accumulator value.
- R4: The offset phase register takes, at each edge, accumulator bits [27:16] plus phase word `phase_sel`, modulo 4096.
- R5: With `wave_mode` = 00 (sine), `sample_out` = floor(511.5 + 511.5*sin(2*pi*k/1024) + 0.5), where k is offset phase bits [11:2]. This puts mid-scale at k = 0.
- R6: With `wave_mode` = 01 (triangle), t = offset phase bits [11:1]. `sample_out` is t[9:0] when t[10] = 0, and the bitwise inverse of t[9:0] when t[10] = 1.
- R7: With `wave_mode` = 10 or 11 (square), `sample_out` is 1023 when offset phase bit 11 is 1, and 0 when it is 0.
- R8: With `clk_div2` = 0, `clk_out` is offset phase bit 11, delayed by one register. With `clk_div2` = 1, `clk_out` toggles once for each 0-to-1 transition of that bit, which halves its frequency.
- R9: When `sleep` is sampled high at edge e, `sample_out` reads 512 after edge e+1 and for as long as `sleep` stays high. `clk_out` is not affected.
- R10: Outputs trail the accumulator by two register stages. A phase word written at edge e appears in `sample_out` after edge e+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_we | input | 1 | Frequency word write strobe |
| freq_wsel | input | 1 | Frequency bank written |
| freq_wdata | input | 28 | Frequency word write data |
| phase_we | input | 1 | Phase word write strobe |
| phase_wsel | input | 1 | Phase bank written |
| phase_wdata | input | 12 | Phase word write data |
| freq_sel | input | 1 | Active frequency bank |
| phase_sel | input | 1 | Active phase bank |
| wave_mode | input | 2 | 00 sine, 01 triangle, 10/11 square |
| clk_div2 | input | 1 | Halve the clock output |
| sleep | input | 1 | Freeze the sample path at mid-scale |
| sample_out | output | 10 | Registered waveform sample |
| clk_out | output | 1 | Registered phase-MSB clock |

## Verification
The assertions assume that `rst` is held high across the first clock edge. They also assume that every control input is stable around each rising edge, so `sleep` and `wave_mode` seen at an edge are the values the design used. The bench meets both conditions: it raises reset from time zero, and it changes every input only on the falling edge. Select and mode changes are made mid-run and at arbitrary phase, so phase continuity and the two-stage output delay are tested while the waveform is moving. The near-Nyquist word is also used so that the clock output toggles on every edge.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'b00,
        WAVE_TRI    = 2'b01,
        WAVE_SQ     = 2'b10,
        WAVE_SQ_ALT = 2'b11
    } wave_e;

    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_ASLEEP = 1'b1
    } out_state_e;

    // Offset-binary sine point over a full period of `depth` entries.
    function automatic int sine_point(input int idx, input int depth, input int width);
        real half;
        real ang;
        half = ((2.0 ** width) - 1.0) / 2.0;
        ang  = 2.0 * 3.14159265358979 * idx / depth;
        return $rtoi($floor(half + half * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freq_we,
    input  logic             freq_wsel,
    input  logic [ACC_W-1:0] freq_wdata,
    input  logic             phase_we,
    input  logic             phase_wsel,
    input  logic [PH_W-1:0]  phase_wdata,
    input  logic             freq_sel,
    input  logic             phase_sel,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  ph_q
);
    localparam int NBANK = 2;

    logic [ACC_W-1:0] fword [NBANK];
    logic [PH_W-1:0]  pword [NBANK];
    logic [ACC_W-1:0] fword_act;
    logic [PH_W-1:0]  pword_act;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                fword[b] <= '0;
                pword[b] <= '0;
            end else begin
                if (freq_we && (int'(freq_wsel) == b))
                    fword[b] <= freq_wdata;
                if (phase_we && (int'(phase_wsel) == b))
                    pword[b] <= phase_wdata;
            end
        end
    end

    assign fword_act = fword[freq_sel];
    assign pword_act = pword[phase_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ph_q  <= '0;
        end else begin
            acc_q <= acc_q + fword_act;
            ph_q  <= acc_q[ACC_W-1 -: PH_W] + pword_act;
        end
    end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int AW = 10,
    parameter int DW = 10
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_pt
        assign table_w[i] = DW'(dds_pkg::sine_point(i, DEPTH, DW));
    end

    assign data = table_w[addr];

endmodule

// File: rtl/dds_wave_out.sv
module dds_wave_out
    import dds_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OUT_W:0]   ph_top,
    input  logic [1:0]       wave_mode,
    input  logic             clk_div2,
    input  logic             sleep,
    output logic [OUT_W-1:0] sample_out,
    output logic             clk_out,
    output out_state_e       state_q
);
    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

    out_state_e       state_d;
    logic [OUT_W-1:0] sine_w;
    logic [OUT_W-1:0] sample_d;
    logic             msb_d;
    logic             div_q;
    logic             div_next;
    logic             msb;

    assign msb = ph_top[OUT_W];

    dds_sine_rom #(.AW(OUT_W), .DW(OUT_W)) u_rom (
        .addr (ph_top[OUT_W -: OUT_W]),
        .data (sine_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (sleep)  state_d = ST_ASLEEP;
            ST_ASLEEP: if (!sleep) state_d = ST_ACTIVE;
            default:               state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACTIVE;
        else     state_q <= state_d;
    end

    always_comb begin
        sample_d = MID;
        unique case (state_q)
            ST_ASLEEP: sample_d = MID;
            ST_ACTIVE: begin
                unique case (wave_e'(wave_mode))
                    WAVE_SINE:   sample_d = sine_w;
                    WAVE_TRI:    sample_d = msb ? ~ph_top[OUT_W-1:0] : ph_top[OUT_W-1:0];
                    WAVE_SQ,
                    WAVE_SQ_ALT: sample_d = {OUT_W{msb}};
                    default:     sample_d = MID;
                endcase
            end
            default: sample_d = MID;
        endcase
    end

    assign div_next = div_q ^ (msb & ~msb_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_out <= MID;
            clk_out    <= 1'b0;
            msb_d      <= 1'b0;
            div_q      <= 1'b0;
        end else begin
            sample_out <= sample_d;
            clk_out    <= clk_div2 ? div_next : msb;
            msb_d      <= msb;
            div_q      <= div_next;
        end
    end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freq_we,
    input  logic             freq_wsel,
    input  logic [ACC_W-1:0] freq_wdata,
    input  logic             phase_we,
    input  logic             phase_wsel,
    input  logic [PH_W-1:0]  phase_wdata,
    input  logic             freq_sel,
    input  logic             phase_sel,
    input  logic [1:0]       wave_mode,
    input  logic             clk_div2,
    input  logic             sleep,
    output logic [OUT_W-1:0] sample_out,
    output logic             clk_out
);
    logic [ACC_W-1:0]     acc_q;
    logic [PH_W-1:0]      ph_q;
    dds_pkg::out_state_e  out_state;

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .freq_we     (freq_we),
        .freq_wsel   (freq_wsel),
        .freq_wdata  (freq_wdata),
        .phase_we    (phase_we),
        .phase_wsel  (phase_wsel),
        .phase_wdata (phase_wdata),
        .freq_sel    (freq_sel),
        .phase_sel   (phase_sel),
        .acc_q       (acc_q),
        .ph_q        (ph_q)
    );

    dds_wave_out #(.OUT_W(OUT_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .ph_top     (ph_q[PH_W-1 -: OUT_W+1]),
        .wave_mode  (wave_mode),
        .clk_div2   (clk_div2),
        .sleep      (sleep),
        .sample_out (sample_out),
        .clk_out    (clk_out),
        .state_q    (out_state)
    );

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                sleep,
    input logic [1:0]          wave_mode,
    input logic                clk_div2,
    input logic [OUT_W-1:0]    sample_out,
    input logic                clk_out,
    input logic [ACC_W-1:0]    acc_q,
    input logic [PH_W-1:0]     ph_q,
    input dds_pkg::out_state_e out_state
);
    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

    // R1
    acc_clear_chk: assert property (@(posedge clk) rst |=> (acc_q == '0 && sample_out == MID && !clk_out));

    // R9
    sleep_mid_chk: assert property (@(posedge clk) disable iff (rst) sleep |-> ##2 (sample_out == MID));

    // R7
    square_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (wave_mode[1] && out_state == dds_pkg::ST_ACTIVE) |=> (sample_out == '0 || sample_out == '1));

    // R8
    clk_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_div2 |=> (clk_out == $past(ph_q[PH_W-1])));

    // R9
    sleep_state_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (out_state == dds_pkg::ST_ASLEEP));

endmodule

bind dds_core dds_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep      (sleep),
    .wave_mode  (wave_mode),
    .clk_div2   (clk_div2),
    .sample_out (sample_out),
    .clk_out    (clk_out),
    .acc_q      (acc_q),
    .ph_q       (ph_q),
    .out_state  (out_state)
);

// File: tb/dds_core_tb.sv
module dds_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freq_we = 1'b0, freq_wsel = 1'b0;
    logic [27:0] freq_wdata = '0;
    logic        phase_we = 1'b0, phase_wsel = 1'b0;
    logic [11:0] phase_wdata = '0;
    logic        freq_sel = 1'b0, phase_sel = 1'b0;
    logic [1:0]  wave_mode = 2'b00;
    logic        clk_div2 = 1'b0, sleep = 1'b0;
    logic [9:0]  sample_out;
    logic        clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    bit armed = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dds_core u_dut (
        .clk(clk), .rst(rst),
        .freq_we(freq_we), .freq_wsel(freq_wsel), .freq_wdata(freq_wdata),
        .phase_we(phase_we), .phase_wsel(phase_wsel), .phase_wdata(phase_wdata),
        .freq_sel(freq_sel), .phase_sel(phase_sel), .wave_mode(wave_mode),
        .clk_div2(clk_div2), .sleep(sleep),
        .sample_out(sample_out), .clk_out(clk_out)
    );

    // Behavioural reference model
    longint m_fw [2];
    int     m_pw [2];
    longint m_acc;
    int     m_ph, m_sample;
    bit     m_clk, m_div, m_msb_d, m_asleep;

    function automatic int sine_ref(input int k);
        return $rtoi($floor(511.5 + 511.5 * $sin(2.0 * 3.14159265358979 * k / 1024.0) + 0.5));
    endfunction

    function automatic int shape(input int ph, input logic [1:0] mode);
        int t;
        if (mode == 2'b00) return sine_ref(ph / 4);
        if (mode == 2'b01) begin
            t = ph / 2;
            return (t >= 1024) ? (1023 - (t % 1024)) : t;
        end
        return (ph >= 2048) ? 1023 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fw[0] = 0; m_fw[1] = 0; m_pw[0] = 0; m_pw[1] = 0;
            m_acc = 0; m_ph = 0; m_sample = 512;
            m_clk = 0; m_div = 0; m_msb_d = 0; m_asleep = 0;
        end else begin
            bit msb, rise;
            msb  = (m_ph >= 2048);
            rise = msb && !m_msb_d;
            m_sample = m_asleep ? 512 : shape(m_ph, wave_mode);
            m_div   = m_div ^ rise;
            m_clk   = clk_div2 ? m_div : msb;
            m_msb_d = msb;
            m_ph    = int'(((m_acc / 65536) + m_pw[phase_sel]) % 4096);
            m_acc   = (m_acc + m_fw[freq_sel]) % 268435456;
            m_asleep = sleep;
            if (freq_we)  m_fw[freq_wsel]  = longint'(freq_wdata);
            if (phase_we) m_pw[phase_wsel] = int'(phase_wdata);
        end
        armed = 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (armed && !done) begin
            check(cur_req, int'(sample_out), m_sample);
            check(cur_req, int'(clk_out), int'(m_clk));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_freq(input bit b, input logic [27:0] v);
        @(negedge clk); freq_we = 1; freq_wsel = b; freq_wdata = v;
        @(negedge clk); freq_we = 0;
    endtask

    task automatic wr_phase(input bit b, input logic [11:0] v);
        @(negedge clk); phase_we = 1; phase_wsel = b; phase_wdata = v;
        @(negedge clk); phase_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        // R1: reset state
        check("R1", int'(sample_out), 512);
        check("R1", int'(clk_out), 0);
        rst = 0;

        // R2, R5: sine run on bank 0
        cur_req = "R5";
        wr_freq(0, 28'h0123457);
        cycles(200);

        // R3, R2: hop to bank 1 mid-run
        cur_req = "R3";
        wr_freq(1, 28'h0400000);
        freq_sel = 1;
        cycles(100);
        freq_sel = 0;
        cycles(40);

        // R4: phase banks
        cur_req = "R4";
        wr_phase(1, 12'h400);
        phase_sel = 1;
        cycles(60);
        wr_phase(0, 12'hA5C);
        phase_sel = 0;
        cycles(60);

        // R6: triangle
        cur_req = "R6";
        wave_mode = 2'b01;
        cycles(200);

        // R7, R8: square with and without halving
        cur_req = "R7";
        wave_mode = 2'b10;
        cycles(150);
        cur_req = "R8";
        clk_div2 = 1;
        wave_mode = 2'b11;
        cycles(300);
        clk_div2 = 0;

        // R9: sleep while running
        cur_req = "R9";
        wave_mode = 2'b00;
        sleep = 1;
        cycles(80);
        sleep = 0;
        cycles(30);

        // Static points, frequency zero
        cur_req = "R1";
        do_reset();
        cycles(3);
        check("R1", int'(sample_out), 512);
        cur_req = "R10";
        @(negedge clk); phase_we = 1; phase_wsel = 0; phase_wdata = 12'h400;
        @(negedge clk); phase_we = 0;
        check("R10", int'(sample_out), 512);   // after write edge
        @(negedge clk);
        check("R10", int'(sample_out), 512);   // after offset stage
        @(negedge clk);
        check("R5", int'(sample_out), 1023);   // peak at k=256
        wave_mode = 2'b01;
        cycles(2);
        check("R6", int'(sample_out), 512);    // rising half
        wr_phase(0, 12'hC00);
        cycles(3);
        check("R6", int'(sample_out), 511);    // falling half inverted
        wave_mode = 2'b00;
        cycles(2);
        check("R5", int'(sample_out), 0);      // trough at k=768

        // R9: sleep timing from a constant level
        cur_req = "R9";
        wr_phase(0, 12'h400);
        cycles(3);
        check("R9", int'(sample_out), 1023);
        sleep = 1;
        @(negedge clk);
        check("R9", int'(sample_out), 1023);
        @(negedge clk);
        check("R9", int'(sample_out), 512);

        // R8/R9: near-Nyquist clock keeps toggling in sleep
        cur_req = "R8";
        wr_phase(0, 12'h000);
        wr_freq(0, 28'h8000000);
        cycles(4);
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = clk_out;
            @(negedge clk);
            check("R8", int'(clk_out), int'(!prev));
            check("R9", int'(sample_out), 512);
        end
        sleep = 0;
        clk_div2 = 1;
        cycles(40);
        clk_div2 = 0;

        // R1: reset mid-run clears accumulator
        cur_req = "R1";
        wr_freq(0, 28'h0333333);
        cycles(50);
        do_reset();
        check("R1", int'(sample_out), 512);
        check("R1", int'(clk_out), 0);
        cycles(20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule